// File: doc/BRIEF.md
# Five-Lane Word Serializer with Selectable Bit Order

This block takes one 5-bit parallel word every five fast-clock cycles and sends it out one bit per cycle on a single serial output. The words follow each other with no gaps. A free-running phase counter raises a one-cycle load strobe every fifth cycle. On that edge the next word is captured in the same cycle that the last bit of the previous word is on the line.

A static order input picks the shift direction. In normal order lane 0 leaves first. In reversed order lane 4 leaves first. The order is sampled only at a word boundary, so a word already in flight keeps the order it was loaded with.

A symbol path lets a 10-bit symbol be sent as two halves. While symbol mode is selected, the first load takes bits 4..0 of the symbol and the second load takes bits 9..5. With normal order, symbol bit 0 leaves first and bit 9 leaves last. A pulse marks the load of each high half, which tells the source it may present the next symbol.

Top module: `ser5_serializer`

## Requirements
- R1: With the order input low (normal) at a load, the captured word leaves as lane 0, 1, 2, 3, 4, starting in the cycle after the load strobe.
- R2: With the order input high (reversed) at a load, the captured word leaves as lane 4, 3, 2, 1, 0.
- R3: The order input is sampled only on load edges. A change between loads does not affect the word in flight.
- R4: `load_stb` is high for exactly one cycle in every five. Its first assertion is in the fifth cycle after reset is released.
- R5: The first bit of each new word appears in the cycle directly after the last bit of the previous word, with no idle cycle between them.
- R6: In symbol mode, the first load takes `sym_in[4:0]` and the next load takes `sym_in[9:5]`. In normal order the line carries `sym_in[0]` first and `sym_in[9]` last.
- R7: `sym_done` pulses together with `load_stb` when, and only when, a high half is captured in symbol mode.
- R8: During reset and for the five cycles after it, `ser_out` is low. `load_stb` and `sym_done` are low during reset. The order returns to normal and the half pointer returns to the low half.
- R9: A load taken with symbol mode off resets the half pointer, so the next symbol-mode load takes the low half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast (serial bit) clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rev | input | 1 | Order select: 0 sends lane 0 first, 1 sends lane 4 first |
| word_in | input | 5 | Parallel word, captured on the load edge when symbol mode is off |
| sym_sel | input | 1 | Symbol mode: take halves of `sym_in` instead of `word_in` |
| sym_in | input | 10 | 10-bit symbol, split into a low half then a high half |
| ser_out | output | 1 | Serial data, one bit per clock |
| load_stb | output | 1 | One-cycle word-boundary strobe, every five cycles |
| sym_done | output | 1 | High during the load of a symbol's high half |

## Verification
The hardest situation to reach is a change of the order input while a word is only partly shifted out. In that case the remaining bits must keep the old direction, and the next load must pick up the new one. The bench toggles the order input at random cycles within words, so the toggle lands at every phase of the word, and it compares each serial bit against a queue-based model that applies the order only at loads. A second hard case is leaving symbol mode between the two halves of a symbol. The bench switches symbol mode on and off at random phases and checks that the next symbol restarts from its low half.

// File: rtl/ser5_pkg.sv
package ser5_pkg;
    localparam int LANES = 5;
    localparam int SYM_W = 2 * LANES;
    localparam int PH_W  = $clog2(LANES);
    localparam int LAST_PH = LANES - 1;

    typedef enum logic {
        ORD_LANE0_FIRST = 1'b0,
        ORD_LANEN_FIRST = 1'b1
    } order_e;

    typedef logic [LANES-1:0] lane_t;
    typedef logic [SYM_W-1:0] sym_t;
    typedef logic [PH_W-1:0]  phase_t;

    typedef struct packed {
        lane_t  bits;
        order_e ord;
    } load_t;

    function automatic lane_t half_of(sym_t s, logic hi);
        return hi ? s[SYM_W-1:LANES] : s[LANES-1:0];
    endfunction
endpackage

// File: rtl/ser5_phase.sv
module ser5_phase
    import ser5_pkg::*;
(
    input  logic clk,
    input  logic rst,
    output logic stb
);
    phase_t cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (cnt == phase_t'(LAST_PH)) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + phase_t'(1);
        end
    end

    assign stb = (cnt == phase_t'(LAST_PH));
endmodule

// File: rtl/ser5_split.sv
module ser5_split
    import ser5_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  stb,
    input  logic  sym_sel,
    input  sym_t  sym_in,
    input  lane_t word_in,
    output lane_t ld_bits,
    output logic  hi_now
);
    logic hi_q;

    // Half pointer: toggles on each symbol-mode load, cleared by a plain load.
    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q <= 1'b0;
        end else if (stb) begin
            hi_q <= sym_sel ? ~hi_q : 1'b0;
        end
    end

    assign ld_bits = sym_sel ? half_of(sym_in, hi_q) : word_in;
    assign hi_now  = sym_sel & hi_q;
endmodule

// File: rtl/ser5_shifter.sv
module ser5_shifter
    import ser5_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   stb,
    input  load_t  ld,
    output logic   ser,
    output order_e ord_q
);
    lane_t sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr    <= '0;
            ord_q <= ORD_LANE0_FIRST;
        end else if (stb) begin
            sr    <= ld.bits;
            ord_q <= ld.ord;
        end else if (ord_q == ORD_LANE0_FIRST) begin
            sr <= {1'b0, sr[LANES-1:1]};
        end else begin
            sr <= {sr[LANES-2:0], 1'b0};
        end
    end

    assign ser = (ord_q == ORD_LANE0_FIRST) ? sr[0] : sr[LANES-1];
endmodule

// File: rtl/ser5_serializer.sv
module ser5_serializer
    import ser5_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_rev,
    input  logic [4:0] word_in,
    input  logic       sym_sel,
    input  logic [9:0] sym_in,
    output logic       ser_out,
    output logic       load_stb,
    output logic       sym_done
);
    lane_t  ld_bits;
    logic   hi_now;
    load_t  ld;
    order_e ord_q;

    ser5_phase u_phase (
        .clk (clk),
        .rst (rst),
        .stb (load_stb)
    );

    ser5_split u_split (
        .clk     (clk),
        .rst     (rst),
        .stb     (load_stb),
        .sym_sel (sym_sel),
        .sym_in  (sym_in),
        .word_in (word_in),
        .ld_bits (ld_bits),
        .hi_now  (hi_now)
    );

    always_comb begin
        ld.bits = ld_bits;
        ld.ord  = order_e'(cfg_rev);
    end

    ser5_shifter u_shift (
        .clk   (clk),
        .rst   (rst),
        .stb   (load_stb),
        .ld    (ld),
        .ser   (ser_out),
        .ord_q (ord_q)
    );

    assign sym_done = load_stb & hi_now;
endmodule

// File: rtl/ser5_chk.sv
module ser5_chk
    import ser5_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  load_stb,
    input logic  sym_done,
    input logic  ser_out,
    input logic  cfg_rev,
    input lane_t ld_bits,
    input logic  ord_q
);
    logic [3:0] gap;
    logic       rst_d = 1'b0;

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst) begin
            gap <= '0;
        end else if (load_stb) begin
            gap <= '0;
        end else if (gap != 4'hF) begin
            gap <= gap + 4'd1;
        end
    end

    assert_stb_spacing_R4: assert property (@(posedge clk) disable iff (rst)
        load_stb |-> (gap == 4'(LAST_PH)));
    assert_stb_due_R4: assert property (@(posedge clk) disable iff (rst)
        (gap == 4'(LAST_PH)) |-> load_stb);
    assert_order_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !load_stb |=> $stable(ord_q));
    assert_first_bit_R1: assert property (@(posedge clk) disable iff (rst)
        load_stb |=> (ser_out == ($past(cfg_rev) ? $past(ld_bits[LANES-1]) : $past(ld_bits[0]))));
    assert_done_on_load_R7: assert property (@(posedge clk) disable iff (rst)
        sym_done |-> load_stb);

    always @(negedge clk) begin
        if (rst_d) begin
            assert_reset_quiet_R8: assert (!ser_out && !load_stb && !sym_done);
        end
    end
endmodule

bind ser5_serializer ser5_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .load_stb (load_stb),
    .sym_done (sym_done),
    .ser_out  (ser_out),
    .cfg_rev  (cfg_rev),
    .ld_bits  (ld_bits),
    .ord_q    (ord_q)
);

// File: tb/tb_ser5_serializer.sv
module tb_ser5_serializer;
    import ser5_pkg::*;

    logic  clk = 1'b0;
    logic  rst = 1'b1;
    logic  cfg_rev = 1'b0;
    logic  sym_sel = 1'b0;
    lane_t word_in = '0;
    sym_t  sym_in = '0;
    logic  ser_out, load_stb, sym_done;

    always #10 clk = ~clk;   // 50 MHz

    ser5_serializer dut (
        .clk      (clk),
        .rst      (rst),
        .cfg_rev  (cfg_rev),
        .word_in  (word_in),
        .sym_sel  (sym_sel),
        .sym_in   (sym_in),
        .ser_out  (ser_out),
        .load_stb (load_stb),
        .sym_done (sym_done)
    );

    int    errors = 0;
    int    checks = 0;
    bit    exp_q[$];
    string tag_q[$];
    int    ph;
    bit    hf;
    bit    prev_sym;
    bit    started;
    bit    r3_seg;
    bit    exp_ser;
    string exp_tag;

    task automatic check(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        exp_q.delete();
        tag_q.delete();
        ph = 0; hf = 0; prev_sym = 0; started = 0;
        exp_ser = 0; exp_tag = "R8";
    endtask

    // Check current outputs, then advance the model across the coming edge.
    task automatic step();
        #1;
        check(exp_tag, ser_out, exp_ser);
        check("R4", load_stb, ph == LAST_PH);
        check("R7", sym_done, (ph == LAST_PH) && sym_sel && hf);
        if (ph == LAST_PH) begin
            lane_t w;
            string t;
            w = sym_sel ? (hf ? sym_in[SYM_W-1:LANES] : sym_in[LANES-1:0]) : word_in;
            if (sym_sel) t = (!hf && !prev_sym) ? "R9" : "R6";
            else if (r3_seg) t = "R3";
            else t = cfg_rev ? "R2" : "R1";
            for (int i = 0; i < LANES; i++) begin
                exp_q.push_back(w[cfg_rev ? LANES-1-i : i]);
                tag_q.push_back((i == 0 && started) ? "R5" : t);
            end
            prev_sym = sym_sel;
            hf = sym_sel ? !hf : 1'b0;   // R9: plain load clears the half pointer
            started = 1;
        end
        ph = (ph + 1) % LANES;
        if (exp_q.size() > 0) begin
            exp_ser = exp_q.pop_front();
            exp_tag = tag_q.pop_front();
        end else begin
            exp_ser = 0;
            exp_tag = "R8";
        end
    endtask

    task automatic do_reset(int n);
        @(negedge clk);
        rst = 1'b1;
        repeat (n) @(negedge clk);
        #1;
        check("R8", ser_out, 1'b0);
        check("R8", load_stb, 1'b0);
        check("R8", sym_done, 1'b0);
        rst = 1'b0;
        model_reset();
        step();
    endtask

    task automatic run(int n, int mode);
        // mode 0: plain words; 1: order toggles; 2: symbols; 3: symbol mode toggles
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            word_in = lane_t'($urandom);
            if (mode == 1 && ($urandom % 3) == 0) cfg_rev = ~cfg_rev;
            if (mode == 3 && ($urandom % 4) == 0) sym_sel = ~sym_sel;
            if ((mode == 2 || mode == 3) && !hf) sym_in = sym_t'($urandom);
            step();
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        do_reset(4);
        // R1: normal order
        cfg_rev = 1'b0; run(60, 0);
        // R2: reversed order
        cfg_rev = 1'b1; run(60, 0);
        // R3: order changes at any phase of a word
        r3_seg = 1'b1; run(120, 1); r3_seg = 1'b0;
        // R6: symbols, normal then reversed; edge pattern T0 and T9 only set
        cfg_rev = 1'b0; sym_sel = 1'b1;
        @(negedge clk); sym_in = 10'b10_0000_0001; step();
        run(9, 0);
        run(100, 2);
        cfg_rev = 1'b1; run(100, 2);
        // R9: symbol mode entered and left at random phases
        cfg_rev = 1'b0; run(150, 3);
        sym_sel = 1'b0;
        // R8: reset in mid-stream, then resume
        do_reset(3);
        run(30, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule